// File: doc/BRIEF.md
# Gap-Modulated Downlink Bit Receiver

This block recovers the bits a reader sends to a tag by briefly switching its carrier field off. It watches a field-present flag on every system clock and a strobe that marks each recovered carrier period. A reader signals a 0 by removing the field early in a bit period. A 1 is a bit period in which the field stays on throughout. The tag's own bit period, counted in carrier strobes, frames each bit.

The receiver stays idle until the tag's sequencer opens the modulated phase of a listen window. A qualified field gap inside that phase, followed by a second gap one bit later, switches the block into receive mode. After that the reader's gaps set the timing: every qualified gap restarts the bit-phase counter, so a few carrier periods gained or lost at the field edges do not break framing. The recovered bits are grouped into 9-bit blocks, each made of 8 data bits and one parity bit. Every complete block is delivered with a parity verdict. The command layer ends receive mode with a release pulse.

Top module: `gap_downlink_rx`

## Requirements
- R1: After reset, rx_active, byte_vld, abort and par_err are all 0.
- R2: The field counts as a gap, and so as a 0, only when field_on is low for at least GAP_MIN consecutive clock cycles. A shorter dip inside a 1 bit leaves that bit a 1.
- R3: While idle, a gap counts only if listen_win is high when it qualifies. Gaps outside the window leave rx_active at 0 and produce no bytes.
- R4: After the first entry gap, a second qualified gap raises rx_active. The two entry zeros are never delivered as data bits.
- R5: After the first entry gap, the second gap must qualify before BIT_TICKS + BIT_TICKS/2 carrier strobes have passed. If it does not, abort pulses high for exactly one cycle, rx_active stays 0, and the block returns to idle.
- R6: In receive mode, a bit period holding a qualified gap yields 0 and one without a gap yields 1. The first received bit lands in byte_data[7], the most significant bit.
- R7: After every ninth received bit, byte_vld pulses for one cycle. byte_data then holds the first eight bits of that block.
- R8: With ODD_PARITY = 0, par_err, which is updated together with byte_vld, is 1 exactly when the nine bits of the block hold an odd number of ones.
- R9: Each qualified gap restarts bit timing. A zero bit that is up to 2 strobes shorter or longer than BIT_TICKS still decodes the surrounding bits correctly.
- R10: A pulse on rx_release returns the block to idle (rx_active 0 on the next cycle) and discards any partly received block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| carrier_tick | input | 1 | One-cycle strobe per extracted carrier period |
| field_on | input | 1 | High while the reader field is present |
| listen_win | input | 1 | High during the modulated phase of a listen window |
| rx_release | input | 1 | Ends receive mode, returns to idle |
| rx_active | output | 1 | Receive mode entered |
| byte_vld | output | 1 | One-cycle strobe: a 9-bit block is complete |
| byte_data | output | DATA_BITS | Data bits of the last block, first received bit in the MSB |
| par_err | output | 1 | Parity verdict of the last block |
| abort | output | 1 | One-cycle strobe: entry failed for lack of a second zero |

## Verification
The bench builds the receiver with BIT_TICKS = 16, GAP_MIN = 2, DATA_BITS = 8 and even parity, and strobes the carrier on every clock. At 16 strobes per bit, a slip of 2 strobes is a large part of the half-bit window. The resynchronising path, where a gap arrives in the second half of the running bit, is therefore hit often by the stretched and shortened zero bits. The abort window is only 24 strobes long, so the failed-entry case and the long runs of ones (an all-ones byte with spikes shorter than GAP_MIN) fit in a short run.

// File: rtl/drx_pkg.sv
package drx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ENTRY = 2'd1,
      ST_SYNC2 = 2'd2,
      ST_RX    = 2'd3
   } drx_state_e;
endpackage

// File: rtl/drx_gap_detect.sv
module drx_gap_detect #(
   parameter int GAP_MIN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic field_on,
   output logic gap_hit
);
   localparam int GW = $clog2(GAP_MIN + 1);
   localparam logic [GW-1:0] GSAT  = GW'(GAP_MIN);
   localparam logic [GW-1:0] GLAST = GW'(GAP_MIN - 1);

   logic [GW-1:0] gcnt;

   // count consecutive field-absent samples, fire once per gap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gcnt    <= '0;
         gap_hit <= 1'b0;
      end else begin
         gap_hit <= 1'b0;
         if (field_on) begin
            gcnt <= '0;
         end else if (gcnt != GSAT) begin
            gcnt <= gcnt + 1'b1;
            if (gcnt == GLAST) gap_hit <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/drx_bit_framer.sv
module drx_bit_framer
   import drx_pkg::*;
#(
   parameter int BIT_TICKS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic gap_hit,
   input  logic listen_win,
   input  logic rx_release,
   output logic bit_vld,
   output logic bit_val,
   output logic rx_active,
   output logic abort
);
   localparam int HALF_TICKS = BIT_TICKS / 2;
   localparam int PW         = $clog2(2 * BIT_TICKS);
   localparam logic [PW-1:0] PH_LAST  = PW'(BIT_TICKS - 1);
   localparam logic [PW-1:0] PH_HALF  = PW'(HALF_TICKS);
   localparam logic [PW-1:0] PH_ABORT = PW'(BIT_TICKS + HALF_TICKS - 1);

   drx_state_e    st;
   logic [PW-1:0] ph;
   logic          zero_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         ph        <= '0;
         zero_pend <= 1'b0;
         bit_vld   <= 1'b0;
         bit_val   <= 1'b0;
         abort     <= 1'b0;
      end else begin
         bit_vld <= 1'b0;
         abort   <= 1'b0;
         if (rx_release) begin
            st        <= ST_IDLE;
            ph        <= '0;
            zero_pend <= 1'b0;
         end else begin
            unique case (st)
               ST_IDLE: begin
                  if (gap_hit && listen_win) begin
                     st <= ST_ENTRY;
                     ph <= '0;
                  end
               end
               ST_ENTRY: begin
                  if (gap_hit) begin
                     st <= ST_SYNC2;
                     ph <= '0;
                  end else if (tick) begin
                     if (ph == PH_ABORT) begin
                        st    <= ST_IDLE;
                        ph    <= '0;
                        abort <= 1'b1;
                     end else begin
                        ph <= ph + 1'b1;
                     end
                  end
               end
               ST_SYNC2: begin
                  // second entry zero is running; data starts at its end
                  if (gap_hit && ph >= PH_HALF) begin
                     st        <= ST_RX;
                     ph        <= '0;
                     zero_pend <= 1'b1;
                  end else if (gap_hit) begin
                     ph <= '0;
                  end else if (tick) begin
                     if (ph == PH_LAST) begin
                        st        <= ST_RX;
                        ph        <= '0;
                        zero_pend <= 1'b0;
                     end else begin
                        ph <= ph + 1'b1;
                     end
                  end
               end
               ST_RX: begin
                  if (gap_hit) begin
                     // a late-half gap closes the running bit early
                     if (ph >= PH_HALF) begin
                        bit_vld <= 1'b1;
                        bit_val <= ~zero_pend;
                     end
                     zero_pend <= 1'b1;
                     ph        <= '0;
                  end else if (tick) begin
                     if (ph == PH_LAST) begin
                        bit_vld   <= 1'b1;
                        bit_val   <= ~zero_pend;
                        zero_pend <= 1'b0;
                        ph        <= '0;
                     end else begin
                        ph <= ph + 1'b1;
                     end
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   assign rx_active = (st == ST_SYNC2) || (st == ST_RX);
endmodule

// File: rtl/drx_block_asm.sv
module drx_block_asm #(
   parameter int DATA_BITS  = 8,
   parameter bit ODD_PARITY = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_active,
   input  logic                 bit_vld,
   input  logic                 bit_val,
   output logic                 byte_vld,
   output logic [DATA_BITS-1:0] byte_data,
   output logic                 par_err
);
   localparam int CW = $clog2(DATA_BITS + 1);
   localparam logic [CW-1:0] CNT_PAR = CW'(DATA_BITS);

   logic [CW-1:0]        cnt;
   logic [DATA_BITS-1:0] sh;
   logic                 ones_odd;
   logic                 par_bad;

   assign ones_odd = ^{sh, bit_val};

   generate
      if (ODD_PARITY) begin : g_odd
         assign par_bad = ~ones_odd;
      end else begin : g_even
         assign par_bad = ones_odd;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         sh        <= '0;
         byte_vld  <= 1'b0;
         byte_data <= '0;
         par_err   <= 1'b0;
      end else begin
         byte_vld <= 1'b0;
         if (!rx_active) begin
            cnt <= '0;
         end else if (bit_vld) begin
            if (cnt == CNT_PAR) begin
               byte_vld  <= 1'b1;
               byte_data <= sh;
               par_err   <= par_bad;
               cnt       <= '0;
            end else begin
               sh  <= {sh[DATA_BITS-2:0], bit_val};
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/gap_downlink_rx.sv
module gap_downlink_rx #(
   parameter int BIT_TICKS  = 64,
   parameter int GAP_MIN    = 2,
   parameter int DATA_BITS  = 8,
   parameter bit ODD_PARITY = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 carrier_tick,
   input  logic                 field_on,
   input  logic                 listen_win,
   input  logic                 rx_release,
   output logic                 rx_active,
   output logic                 byte_vld,
   output logic [DATA_BITS-1:0] byte_data,
   output logic                 par_err,
   output logic                 abort
);
   generate
      if (BIT_TICKS < 8 || (BIT_TICKS % 2) != 0) begin : g_bad_bit
         $error("BIT_TICKS must be even and at least 8");
      end
      if (GAP_MIN < 1 || GAP_MIN >= BIT_TICKS / 2) begin : g_bad_gap
         $error("GAP_MIN must lie in 1 .. BIT_TICKS/2-1");
      end
      if (DATA_BITS < 2) begin : g_bad_data
         $error("DATA_BITS must be at least 2");
      end
   endgenerate

   logic gap_hit;
   logic bit_vld;
   logic bit_val;

   drx_gap_detect #(.GAP_MIN(GAP_MIN)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .field_on(field_on),
      .gap_hit (gap_hit)
   );

   drx_bit_framer #(.BIT_TICKS(BIT_TICKS)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (carrier_tick),
      .gap_hit   (gap_hit),
      .listen_win(listen_win),
      .rx_release(rx_release),
      .bit_vld   (bit_vld),
      .bit_val   (bit_val),
      .rx_active (rx_active),
      .abort     (abort)
   );

   drx_block_asm #(.DATA_BITS(DATA_BITS), .ODD_PARITY(ODD_PARITY)) u_asm (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_active(rx_active),
      .bit_vld  (bit_vld),
      .bit_val  (bit_val),
      .byte_vld (byte_vld),
      .byte_data(byte_data),
      .par_err  (par_err)
   );
endmodule

// File: rtl/drx_checker.sv
module drx_checker (
   input logic clk,
   input logic rst_n,
   input logic rx_release,
   input logic rx_active,
   input logic byte_vld,
   input logic par_err,
   input logic abort
);
   a_r7_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |=> !byte_vld);

   a_r7_vld_in_rx: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> $past(rx_active));

   a_r8_err_moves_with_vld: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(par_err) |-> byte_vld);

   a_r5_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> !rx_active);

   a_r5_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !abort);

   a_r10_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
      rx_release |=> !rx_active);
endmodule

bind gap_downlink_rx drx_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_release(rx_release),
   .rx_active (rx_active),
   .byte_vld  (byte_vld),
   .par_err   (par_err),
   .abort     (abort)
);

// File: tb/gap_downlink_rx_tb.sv
`timescale 1ns/1ps
module gap_downlink_rx_tb;
   localparam int BT      = 16;
   localparam int GMIN    = 2;
   localparam int GAP_LEN = 4;
   localparam int NV      = 8;

   // {data, flip parity, slip zero bits}
   localparam logic [9:0] VEC [NV] = '{
      {8'h01, 1'b0, 1'b0},
      {8'hA5, 1'b0, 1'b0},
      {8'h00, 1'b0, 1'b1},
      {8'hFF, 1'b0, 1'b0},
      {8'h3C, 1'b1, 1'b0},
      {8'h80, 1'b0, 1'b1},
      {8'h5A, 1'b1, 1'b1},
      {8'h12, 1'b0, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       carrier_tick = 1'b1;
   logic       field_on = 1'b1;
   logic       listen_win = 1'b0;
   logic       rx_release = 1'b0;
   logic       rx_active;
   logic       byte_vld;
   logic [7:0] byte_data;
   logic       par_err;
   logic       abort;

   int checks = 0;
   int fails  = 0;
   int nrx    = 0;
   int nabort = 0;
   int cyc    = 0;
   logic [7:0] rx_b [16];
   logic       rx_e [16];
   bit   sl_toggle = 1'b0;

   always #5 clk = ~clk;

   gap_downlink_rx #(.BIT_TICKS(BT), .GAP_MIN(GMIN), .DATA_BITS(8), .ODD_PARITY(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .carrier_tick(carrier_tick), .field_on(field_on),
      .listen_win(listen_win), .rx_release(rx_release), .rx_active(rx_active),
      .byte_vld(byte_vld), .byte_data(byte_data), .par_err(par_err), .abort(abort)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (byte_vld && nrx < 16) begin
            rx_b[nrx] = byte_data;
            rx_e[nrx] = par_err;
            nrx++;
         end
         if (abort) nabort++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   // one bit period; glitch puts a 1-cycle dip in a 1 bit
   task automatic send_bit(input bit b, input int len, input bit glitch);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (!b) field_on = (i >= GAP_LEN);
         else    field_on = !(glitch && i == 8);
      end
      @(negedge clk);
      field_on = 1'b1;
   endtask

   task automatic send_bit_n(input bit b, input int len, input bit glitch);
      // send_bit consumes len+1 edges; trim to keep period exactly len
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (!b) field_on = (i >= GAP_LEN);
         else    field_on = !(glitch && i == 8);
      end
   endtask

   task automatic send_block(input logic [7:0] d, input bit flip, input bit slip, input bit glitch);
      logic [8:0] blk;
      blk = {d, (^d) ^ flip};
      for (int k = 8; k >= 0; k--) begin
         int len;
         len = BT;
         if (slip && !blk[k]) begin
            len = sl_toggle ? BT + 2 : BT - 2;
            sl_toggle = ~sl_toggle;
         end
         send_bit_n(blk[k], len, glitch);
      end
   endtask

   task automatic enter_rx();
      listen_win = 1'b1;
      send_bit_n(1'b0, BT, 1'b0);
      listen_win = 1'b0;
      send_bit_n(1'b0, BT, 1'b0);
   endtask

   task automatic release_rx();
      @(negedge clk);
      field_on   = 1'b1;
      rx_release = 1'b1;
      @(negedge clk);
      rx_release = 1'b0;
   endtask

   initial begin
      int base;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(rx_active == 1'b0 && byte_vld == 1'b0 && abort == 1'b0 && par_err == 1'b0,
          "R1 reset outputs", {rx_active, byte_vld, abort, par_err}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3: zeros outside the listen window are ignored
      send_bit_n(1'b0, BT, 1'b0);
      send_bit_n(1'b0, BT, 1'b0);
      send_bit_n(1'b1, BT, 1'b0);
      chk(rx_active == 1'b0, "R3 no entry without window", rx_active, 0);
      chk(nrx == 0, "R3 no bytes without window", nrx, 0);

      // R4: entry by two zeros
      enter_rx();
      chk(rx_active == 1'b1, "R4 receive mode after two zeros", rx_active, 1);

      // R6 R7 R8 R9: vector table walk
      for (int v = 0; v < NV; v++)
         send_block(VEC[v][9:2], VEC[v][1], VEC[v][0], 1'b0);
      repeat (6) @(negedge clk);
      for (int v = 0; v < NV; v++) begin
         chk(rx_b[v] == VEC[v][9:2], VEC[v][0] ? "R9 byte with slipped zeros" : "R6 R7 byte value",
             rx_b[v], VEC[v][9:2]);
         chk(rx_e[v] == VEC[v][1], "R8 parity verdict", rx_e[v], VEC[v][1]);
      end
      chk(nrx == NV, "R7 block count", nrx, NV);

      // R10: release ends receive mode, partial block discarded
      send_bit_n(1'b0, BT, 1'b0);
      send_bit_n(1'b1, BT, 1'b0);
      release_rx();
      @(negedge clk);
      chk(rx_active == 1'b0, "R10 idle after release", rx_active, 0);

      // R5: first zero in window, no second zero
      listen_win = 1'b1;
      send_bit_n(1'b0, BT, 1'b0);
      listen_win = 1'b0;
      send_bit_n(1'b1, BT, 1'b0);
      send_bit_n(1'b1, BT, 1'b0);
      chk(nabort == 1, "R5 abort pulse count", nabort, 1);
      chk(rx_active == 1'b0, "R5 stays idle after abort", rx_active, 0);

      // R2: short dips are not zeros; fresh block after release (R10)
      base = nrx;
      enter_rx();
      send_block(8'hFF, 1'b0, 1'b0, 1'b1);
      repeat (6) @(negedge clk);
      chk(nrx == base + 1, "R2 one block received", nrx, base + 1);
      chk(rx_b[base] == 8'hFF, "R2 dips ignored, R10 no stale bits", rx_b[base], 8'hFF);
      chk(rx_e[base] == 1'b0, "R2 parity clean", rx_e[base], 0);
      release_rx();

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule